// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block keeps two small pending vectors, one bit per processor: one for inter-processor interrupts and one for interval-timer interrupts. Each bit drives a level interrupt output for its processor, so a processor sees its inter-processor and timer interrupts on two separate lines. A periodic tick input marks a timer interrupt as pending for every processor that is present. Software posts and retires inter-processor interrupts, and retires timer interrupts, over a 64-bit register bus.

A write to the control register carries three independent per-processor fields: request inter-processor, clear inter-processor and clear timer. One write can use any of them together. The write also carries a separate acknowledge bit that has no effect. Three dedicated registers do the same operations, one operation each, with the processor mask in their low bits. A write that names nothing, or that targets an unmapped offset, gives a one-cycle error pulse. A request or clear that finds nothing to do gives a one-cycle warning pulse. A control read returns both vectors and the identifier of the reading processor.

Top module: `ipt_intr_ctrl`

## Requirements
- R1: After reset both pending vectors are zero, every interrupt output is low, and the error, warning and read-valid outputs are low.
- R2: A write to offset 0 (control) with any of bits 15:12 set makes the inter-processor pending bit of each processor whose bit is set go high after the clock edge that takes the write.
- R3: In a control write, bits 11:8 clear the matching inter-processor pending bits. The request field is applied first, so a processor that is both requested and cleared in one write ends up not pending.
- R4: In a control write, bits 7:4 clear the matching timer pending bits.
- R5: A control write whose only set bit is bit 28 is accepted with no state change and no error. A control write with none of bits 15:4 or 28 set raises the error output for one cycle and changes no state.
- R6: The warning output pulses for one cycle after a write that requests an inter-processor interrupt for a processor that already has one pending. It also pulses after a write that clears one that is not pending, counting a request in the same write. Neither case changes the bit.
- R7: A tick sets the timer pending bit of every present processor. If a timer clear for the same processor arrives in the same cycle, the tick wins.
- R8: Offset 1 requests inter-processor interrupts, offset 2 clears them and offset 3 clears timer interrupts. Each of these uses write-data bits 3:0 as the processor mask.
- R9: A write to offset 1, 2 or 3 whose bits 3:0 are zero, or a write to offsets 4 to 7, raises the error output for one cycle and changes no state.
- R10: A read returns data with read-valid high in the cycle after the request. At offset 0 the data holds the inter-processor vector in bits 11:8, the timer vector in bits 7:4, the reader's identifier in bits 1:0, and zero elsewhere. Any other offset reads as zero.
- R11: Each interrupt output follows its pending bit. The error and warning outputs are high only in the cycle after an offending write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Periodic timer tick |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 64 | Write data |
| bus_cpu_i | input | 2 | Identifier of the processor making the access |
| bus_rdata_o | output | 64 | Read data |
| bus_rvalid_o | output | 1 | Read data valid |
| ipi_irq_o | output | 4 | Per-processor inter-processor interrupt level |
| tmr_irq_o | output | 4 | Per-processor timer interrupt level |
| err_o | output | 1 | Illegal write pulse |
| warn_o | output | 1 | Redundant request or clear pulse |

## Verification
Directed writes cover these cases:
- a control write that requests and clears the same processor, which shows whether the request is applied before the clear;
- an acknowledge-only write set against an empty write, which separates the accepted no-op from the error;
- a duplicate request and a clear of an idle bit, which show the warning path;
- a tick in the same cycle as a timer clear, which exposes the priority between them.

Random writes then mix the three control fields, the dedicated registers, zero masks, unmapped offsets, ticks and reads. This exercises the vectors in many states that the directed cases do not reach.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
   localparam int unsigned MAX_CPU = 4;

   typedef enum logic [2:0] {
      RA_CTRL    = 3'd0,
      RA_IPI_SET = 3'd1,
      RA_IPI_CLR = 3'd2,
      RA_TMR_CLR = 3'd3
   } reg_addr_e;

   typedef struct packed {
      logic [MAX_CPU-1:0] ipi_set;
      logic [MAX_CPU-1:0] ipi_clr;
      logic [MAX_CPU-1:0] tmr_clr;
      logic               bad;
   } wr_cmd_t;
endpackage

// File: rtl/ipt_pend_cell.sv
module ipt_pend_cell #(
   parameter bit SET_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o,
   output logic warn_set_o,
   output logic warn_clr_o
);
   logic q_n;

   generate
      if (SET_FIRST) begin : g_set_then_clr
         always_comb begin
            q_n        = (q_o | set_i) & ~clr_i;
            warn_set_o = set_i & q_o;
            warn_clr_o = clr_i & ~(q_o | set_i);
         end
      end else begin : g_clr_then_set
         always_comb begin
            q_n        = (q_o & ~clr_i) | set_i;
            warn_set_o = set_i & q_o & ~clr_i;
            warn_clr_o = clr_i & ~q_o;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= q_n;
   end
endmodule

// File: rtl/ipt_wr_decode.sv
module ipt_wr_decode
   import ipt_pkg::*;
#(
   parameter int unsigned NUM_CPU    = 4,
   parameter int unsigned BUS_W      = 64,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned REQ_LSB    = 12,
   parameter int unsigned IPICLR_LSB = 8,
   parameter int unsigned TMRCLR_LSB = 4,
   parameter int unsigned ACK_BIT    = 28,
   parameter logic [NUM_CPU-1:0] PRESENT_MASK = '1
) (
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output wr_cmd_t           cmd_o
);
   localparam int unsigned FIELD_W = MAX_CPU;
   localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(RA_CTRL);
   localparam logic [ADDR_W-1:0] A_IPI_SET = ADDR_W'(RA_IPI_SET);
   localparam logic [ADDR_W-1:0] A_IPI_CLR = ADDR_W'(RA_IPI_CLR);
   localparam logic [ADDR_W-1:0] A_TMR_CLR = ADDR_W'(RA_TMR_CLR);

   logic [FIELD_W-1:0] f_req, f_iclr, f_tclr;
   logic [NUM_CPU-1:0] f_low;
   logic               f_ack, ctrl_hit, low_hit;
   logic               unused_wdata;

   assign f_req    = wdata_i[REQ_LSB    +: FIELD_W];
   assign f_iclr   = wdata_i[IPICLR_LSB +: FIELD_W];
   assign f_tclr   = wdata_i[TMRCLR_LSB +: FIELD_W];
   assign f_ack    = wdata_i[ACK_BIT];
   assign f_low    = wdata_i[NUM_CPU-1:0];
   assign ctrl_hit = (|f_req) | (|f_iclr) | (|f_tclr) | f_ack;
   assign low_hit  = |f_low;
   assign unused_wdata = ^wdata_i;

   always_comb begin
      cmd_o = '0;
      if (wr_i) begin
         unique case (addr_i)
            A_CTRL: begin
               if (ctrl_hit) begin
                  cmd_o.ipi_set[NUM_CPU-1:0] = f_req[NUM_CPU-1:0]  & PRESENT_MASK;
                  cmd_o.ipi_clr[NUM_CPU-1:0] = f_iclr[NUM_CPU-1:0] & PRESENT_MASK;
                  cmd_o.tmr_clr[NUM_CPU-1:0] = f_tclr[NUM_CPU-1:0] & PRESENT_MASK;
               end else begin
                  cmd_o.bad = 1'b1;
               end
            end
            A_IPI_SET: begin
               if (low_hit) cmd_o.ipi_set[NUM_CPU-1:0] = f_low & PRESENT_MASK;
               else         cmd_o.bad = 1'b1;
            end
            A_IPI_CLR: begin
               if (low_hit) cmd_o.ipi_clr[NUM_CPU-1:0] = f_low & PRESENT_MASK;
               else         cmd_o.bad = 1'b1;
            end
            A_TMR_CLR: begin
               if (low_hit) cmd_o.tmr_clr[NUM_CPU-1:0] = f_low & PRESENT_MASK;
               else         cmd_o.bad = 1'b1;
            end
            default: cmd_o.bad = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/ipt_readback.sv
module ipt_readback
   import ipt_pkg::*;
#(
   parameter int unsigned NUM_CPU    = 4,
   parameter int unsigned BUS_W      = 64,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned IPICLR_LSB = 8,
   parameter int unsigned TMRCLR_LSB = 4,
   parameter bit          RD_REG     = 1'b1,
   localparam int unsigned ID_W      = $clog2(NUM_CPU)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [ID_W-1:0]    cpu_i,
   input  logic [NUM_CPU-1:0] ipi_i,
   input  logic [NUM_CPU-1:0] tmr_i,
   output logic [BUS_W-1:0]   rdata_o,
   output logic               rvalid_o
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(RA_CTRL);

   logic [BUS_W-1:0] word;

   always_comb begin
      word = '0;
      if (addr_i == A_CTRL) begin
         word[IPICLR_LSB +: NUM_CPU] = ipi_i;
         word[TMRCLR_LSB +: NUM_CPU] = tmr_i;
         word[ID_W-1:0]              = cpu_i;
      end
   end

   generate
      if (RD_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata_o  <= '0;
               rvalid_o <= 1'b0;
            end else begin
               rvalid_o <= rd_i;
               rdata_o  <= rd_i ? word : '0;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rvalid_o   = rd_i;
         assign rdata_o    = rd_i ? word : '0;
      end
   endgenerate
endmodule

// File: rtl/ipt_intr_ctrl.sv
module ipt_intr_ctrl
   import ipt_pkg::*;
#(
   parameter int unsigned NUM_CPU    = 4,
   parameter int unsigned BUS_W      = 64,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned REQ_LSB    = 12,
   parameter int unsigned IPICLR_LSB = 8,
   parameter int unsigned TMRCLR_LSB = 4,
   parameter int unsigned ACK_BIT    = 28,
   parameter logic [NUM_CPU-1:0] PRESENT_MASK = '1,
   parameter bit          RD_REG     = 1'b1,
   localparam int unsigned ID_W      = $clog2(NUM_CPU)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               bus_wr_i,
   input  logic               bus_rd_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [BUS_W-1:0]   bus_wdata_i,
   input  logic [ID_W-1:0]    bus_cpu_i,
   output logic [BUS_W-1:0]   bus_rdata_o,
   output logic               bus_rvalid_o,
   output logic [NUM_CPU-1:0] ipi_irq_o,
   output logic [NUM_CPU-1:0] tmr_irq_o,
   output logic               err_o,
   output logic               warn_o
);
   initial begin
      assert (NUM_CPU >= 2 && NUM_CPU <= MAX_CPU)
         else $error("NUM_CPU must be 2..%0d", MAX_CPU);
      assert (BUS_W > ACK_BIT && BUS_W >= REQ_LSB + MAX_CPU)
         else $error("bus too narrow for control fields");
      assert (ADDR_W >= 2) else $error("ADDR_W must reach the dedicated registers");
      assert (TMRCLR_LSB >= ID_W) else $error("identifier overlaps timer field");
   end

   wr_cmd_t            cmd;
   logic [NUM_CPU-1:0] ipi_q, tmr_q, ipi_wset, ipi_wclr;
   logic               err_q, warn_q;

   ipt_wr_decode #(
      .NUM_CPU(NUM_CPU), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
      .REQ_LSB(REQ_LSB), .IPICLR_LSB(IPICLR_LSB), .TMRCLR_LSB(TMRCLR_LSB),
      .ACK_BIT(ACK_BIT), .PRESENT_MASK(PRESENT_MASK)
   ) u_dec (
      .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .cmd_o(cmd)
   );

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
      if (PRESENT_MASK[i]) begin : g_present
         logic tmr_unused_ws, tmr_unused_wc;
         ipt_pend_cell #(.SET_FIRST(1'b1)) u_ipi (
            .clk(clk), .rst_n(rst_n),
            .set_i(cmd.ipi_set[i]), .clr_i(cmd.ipi_clr[i]),
            .q_o(ipi_q[i]), .warn_set_o(ipi_wset[i]), .warn_clr_o(ipi_wclr[i])
         );
         ipt_pend_cell #(.SET_FIRST(1'b0)) u_tmr (
            .clk(clk), .rst_n(rst_n),
            .set_i(tick_i), .clr_i(cmd.tmr_clr[i]),
            .q_o(tmr_q[i]), .warn_set_o(tmr_unused_ws), .warn_clr_o(tmr_unused_wc)
         );
      end else begin : g_absent
         assign ipi_q[i]    = 1'b0;
         assign tmr_q[i]    = 1'b0;
         assign ipi_wset[i] = 1'b0;
         assign ipi_wclr[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         warn_q <= 1'b0;
      end else begin
         err_q  <= cmd.bad;
         warn_q <= |(ipi_wset | ipi_wclr);
      end
   end

   ipt_readback #(
      .NUM_CPU(NUM_CPU), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
      .IPICLR_LSB(IPICLR_LSB), .TMRCLR_LSB(TMRCLR_LSB), .RD_REG(RD_REG)
   ) u_rb (
      .clk(clk), .rst_n(rst_n), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
      .cpu_i(bus_cpu_i), .ipi_i(ipi_q), .tmr_i(tmr_q),
      .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
   );

   assign ipi_irq_o = ipi_q;
   assign tmr_irq_o = tmr_q;
   assign err_o     = err_q;
   assign warn_o    = warn_q;
endmodule

// File: rtl/ipt_intr_ctrl_chk.sv
module ipt_intr_ctrl_chk #(
   parameter int unsigned NUM_CPU = 4,
   parameter int unsigned BUS_W   = 64,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned REQ_LSB = 12,
   parameter logic [NUM_CPU-1:0] PRESENT_MASK = '1,
   parameter bit          RD_REG  = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick_i,
   input logic               bus_wr_i,
   input logic               bus_rd_i,
   input logic [ADDR_W-1:0]  bus_addr_i,
   input logic [BUS_W-1:0]   bus_rdata_o,
   input logic               bus_rvalid_o,
   input logic [NUM_CPU-1:0] ipi_irq_o,
   input logic [NUM_CPU-1:0] tmr_irq_o,
   input logic               err_o
);
   AST_TICK_SETS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> ((tmr_irq_o & PRESENT_MASK) == PRESENT_MASK)); // R7

   AST_IPI_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((ipi_irq_o & ~$past(ipi_irq_o)) != '0) |->
         ($past(bus_wr_i) && ($past(bus_addr_i) <= ADDR_W'(1)))); // R2

   AST_TMR_FALL_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      ((~tmr_irq_o & $past(tmr_irq_o)) != '0) |-> $past(bus_wr_i)); // R4

   AST_ERR_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(bus_wr_i)); // R11

   AST_ERR_KEEPS_IPI: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (ipi_irq_o == $past(ipi_irq_o))); // R9

   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid_o |-> (bus_rdata_o[BUS_W-1:REQ_LSB] == '0)); // R10

   generate
      if (RD_REG) begin : g_rd_lat
         AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rd_i |=> bus_rvalid_o); // R10
         AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_rd_i |=> !bus_rvalid_o); // R10
      end
   endgenerate
endmodule

bind ipt_intr_ctrl ipt_intr_ctrl_chk #(
   .NUM_CPU(NUM_CPU), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .REQ_LSB(REQ_LSB),
   .PRESENT_MASK(PRESENT_MASK), .RD_REG(RD_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
   .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
   .bus_rvalid_o(bus_rvalid_o), .ipi_irq_o(ipi_irq_o), .tmr_irq_o(tmr_irq_o),
   .err_o(err_o)
);

// File: tb/ipt_intr_ctrl_bench.sv
module ipt_intr_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0, bus_wr_i = 1'b0, bus_rd_i = 1'b0;
   logic [2:0]  bus_addr_i = '0;
   logic [63:0] bus_wdata_i = '0;
   logic [1:0]  bus_cpu_i = '0;
   logic [63:0] bus_rdata_o;
   logic        bus_rvalid_o, err_o, warn_o;
   logic [3:0]  ipi_irq_o, tmr_irq_o;

   int   n_checks = 0, n_errors = 0;
   logic [3:0] ipi_m = '0, tmr_m = '0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipt_intr_ctrl u_ipt_intr_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
      .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
      .bus_cpu_i(bus_cpu_i), .bus_rdata_o(bus_rdata_o), .bus_rvalid_o(bus_rvalid_o),
      .ipi_irq_o(ipi_irq_o), .tmr_irq_o(tmr_irq_o), .err_o(err_o), .warn_o(warn_o)
   );

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Reference model of one write; updates ipi_m/tmr_m, returns err/warn.
   task automatic model_write(logic [2:0] a, logic [63:0] d, output bit e, output bit w);
      logic [3:0] s, ic, tc, f;
      e = 0; w = 0;
      s = d[15:12]; ic = d[11:8]; tc = d[7:4]; f = d[3:0];
      case (a)
         3'd0: if (s == 0 && ic == 0 && tc == 0 && !d[28]) e = 1;
               else begin
                  w = |(s & ipi_m) || |(ic & ~(ipi_m | s));
                  ipi_m = (ipi_m | s) & ~ic;
                  tmr_m = tmr_m & ~tc;
               end
         3'd1: if (f == 0) e = 1; else begin w = |(f & ipi_m); ipi_m |= f; end
         3'd2: if (f == 0) e = 1; else begin w = |(f & ~ipi_m); ipi_m &= ~f; end
         3'd3: if (f == 0) e = 1; else tmr_m &= ~f;
         default: e = 1;
      endcase
   endtask

   task automatic op(string tag, bit wr, bit rd, logic [2:0] a, logic [63:0] d,
                     bit tk, logic [1:0] id);
      bit e = 0, w = 0;
      logic [63:0] rexp;
      rexp = (a == 3'd0) ? {52'd0, ipi_m, tmr_m, 2'b00, id} : 64'd0;
      if (wr) model_write(a, d, e, w);
      if (tk) tmr_m = 4'hF;
      @(negedge clk);
      bus_wr_i = wr; bus_rd_i = rd; bus_addr_i = a; bus_wdata_i = d;
      tick_i = tk; bus_cpu_i = id;
      @(posedge clk); #2;
      bus_wr_i = 0; bus_rd_i = 0; tick_i = 0;
      check({tag, " ipi"}, 64'(ipi_irq_o), 64'(ipi_m));
      check({tag, " tmr"}, 64'(tmr_irq_o), 64'(tmr_m));
      check({tag, " err"}, 64'(err_o), 64'(e));
      check({tag, " warn"}, 64'(warn_o), 64'(w));
      check({tag, " rvalid"}, 64'(bus_rvalid_o), 64'(rd));
      if (rd) check({tag, " rdata"}, bus_rdata_o, rexp);
   endtask

   task automatic wr(string tag, logic [2:0] a, logic [63:0] d);
      op(tag, 1, 0, a, d, 0, 2'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      check("R1 ipi", 64'(ipi_irq_o), 0);
      check("R1 tmr", 64'(tmr_irq_o), 0);
      check("R1 err", 64'(err_o), 0);
      check("R1 warn", 64'(warn_o), 0);
      check("R1 rvalid", 64'(bus_rvalid_o), 0);
      @(negedge clk); rst_n = 1;

      wr("R2 ctrl request", 3'd0, 64'h3000);
      op("R10 ctrl read", 0, 1, 3'd0, 0, 0, 2'd2);
      wr("R6 duplicate request", 3'd0, 64'h1000);
      wr("R6 clear idle", 3'd0, 64'h0400);
      wr("R3 request and clear same cpu", 3'd0, 64'h8800);
      wr("R3 ctrl clear", 3'd0, 64'h0100);
      wr("R5 ack only", 3'd0, 64'h1000_0000);
      wr("R5 empty ctrl", 3'd0, 64'hFFFF_0000_0000_000F);
      op("R7 tick", 0, 0, 3'd0, 0, 1, 2'd0);
      wr("R4 ctrl timer clear", 3'd0, 64'h0050);
      op("R7 tick beats clear", 1, 0, 3'd3, 64'h2, 1, 2'd0);
      wr("R8 ded request", 3'd1, 64'h5);
      wr("R8 ded ipi clear", 3'd2, 64'h4);
      wr("R8 ded tmr clear", 3'd3, 64'hC);
      wr("R9 ded zero mask", 3'd1, 64'hF0);
      wr("R9 ded zero clear", 3'd2, 64'h0);
      wr("R9 unmapped", 3'd5, 64'hF);
      op("R10 other read", 0, 1, 3'd1, 0, 0, 2'd3);
      op("R11 idle", 0, 0, 3'd0, 0, 0, 2'd0);
      op("R10 ctrl read2", 0, 1, 3'd0, 0, 0, 2'd1);

      for (int k = 0; k < 400; k++) begin
         logic [63:0] d;
         logic [2:0]  a;
         int sel;
         sel = $urandom % 10;
         a = (sel < 5) ? 3'd0 : (sel < 9) ? 3'(1 + $urandom % 3) : 3'(4 + $urandom % 4);
         d = 64'($urandom);
         d[63:32] = ($urandom % 8 == 0) ? 32'($urandom) : 32'd0;
         if ($urandom % 4 == 0) d[15:0] = 16'd0;
         if ($urandom % 3 == 0) d[3:0] = 4'd0;
         if ($urandom % 2 == 0) d[28] = 1'b0;
         if ($urandom % 6 == 0)
            op("R10 random read", 0, 1, 3'($urandom % 8), 0, 0, 2'($urandom));
         else
            op("R11 random write", 1, 0, a, d, ($urandom % 6 == 0), 2'd0);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule